// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It first looks in a small direct-mapped translation cache. On a miss it walks a two-level structure in memory: a directory entry, then a table entry, both fetched through a single request port with a valid/ready handshake. While walking, it sets the accessed and dirty bits of the entries in memory. It writes an entry back only when one of those bits actually changes.

The permissions it returns are the directory and table permissions combined. It checks them against the access type, the privilege level of the requester and a write-protect enable. If the check fails, it flags a page fault with a 3-bit error code and latches the faulting linear address.

A flush input invalidates the whole cache. The flush is swept one entry per cycle, and it is skipped entirely when no entry is valid. Translation requests are taken one at a time. Each accepted request produces exactly one single-cycle response.

Top module: `xlat_walker`

## Requirements
- R1: The directory entry is read at `dir_base + lin[31:22]*4`. The table entry is read at `{directory[31:12], lin[21:12], 2'b00}`.
- R2: If bit 0 (present) of the directory entry or of the table entry is clear, the walk stops with no further memory access. It returns frame 0 with the present flag low, and nothing is cached.
- R3: When bit 5 (accessed) of the directory entry is clear, the entry is written back with bit 5 set before the table entry is read; otherwise the directory entry is not written.
- R4: The table entry is written back only when its bit 5 is clear, or when the access is a write and its bit 6 (dirty) is clear. The written value has bit 5 set, and also bit 6 for a write. This happens even when the access then faults.
- R5: The returned writable (bit 1) and user (bit 2) permissions are the AND of the directory bit and the table bit.
- R6: `resp_fault` is high when the result is not present, or the page is supervisor-only with `req_cpl_nz` high, or the access is a write with `wp_en` high and the page read-only.
- R7: `resp_ecode` is {privilege nonzero, write, present}. On a fault, `fault_addr` takes the request's linear address one cycle after the response.
- R8: `resp_phys` is the frame number shifted left by 12 and ORed with `lin[11:0]`.
- R9: A hit in the cache makes no memory access. The cache index is `lin[12 +: log2(SETS)]`, and the tag is the rest of `lin[31:12]`. A refill evicts the previous entry of that set. A write that hits an entry whose dirty bit is clear is handled as a miss.
- R10: A flush invalidates all entries. If any entry is valid, `req_ready` stays low for SETS+1 cycles after the flush pulse is sampled; if none is valid, it stays low for 1 cycle.
- R11: A memory request keeps `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready` accepts it. Read data is taken on `mem_rvalid`.
- R12: After reset, `req_ready` is 1, while `resp_valid`, `mem_valid` and `fault_addr` are 0. Every accepted request gives exactly one single-cycle `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_base | input | 32 | Directory base address, sampled with each request |
| wp_en | input | 1 | Write-protect enable, sampled with each request |
| flush | input | 1 | Pulse that invalidates the translation cache |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_lin | input | 32 | Linear address |
| req_wr | input | 1 | Access is a write |
| req_cpl_nz | input | 1 | Requester privilege level is nonzero |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_phys | output | 32 | Physical address |
| resp_fault | output | 1 | Page fault |
| resp_ecode | output | 3 | Fault error code |
| fault_addr | output | 32 | Last faulting linear address |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench keeps a small memory with entries in deliberately different states:
- with the accessed bit clear or set,
- with the dirty bit clear or set,
- writable or read-only,
- user or supervisor,
- absent at either level.

Repeated requests to the same page separate a first walk from a cache hit and from a write to a clean cached entry, which must walk again. Counting the memory reads and writes for each response makes a wrong write-back policy, an extra walk or a missed hit visible. A second page in the same set checks eviction. Flushing with the cache full and then empty separates a real sweep from a skipped one by how long `req_ready` stays low. The memory withholds ready on a fixed pattern, so held requests are exercised throughout.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W  = 32;
  localparam int PG_SH = 12;
  localparam int VPN_W = VA_W - PG_SH;
  localparam int IDX_W = 10;

  // entry bit positions decoded by the memory-resident structures
  localparam int B_PRES  = 0;
  localparam int B_WR    = 1;
  localparam int B_USR   = 2;
  localparam int B_ACC   = 5;
  localparam int B_DIRTY = 6;

  typedef struct packed {
    logic [VPN_W-1:0] frame;
    logic             wr_ok;
    logic             usr_ok;
    logic             dirty;
    logic             present;
  } xw_ent_t;

  typedef struct packed {
    logic [VPN_W-1:0] frame;
    logic             wr_ok;
    logic             usr_ok;
    logic             present;
  } xw_res_t;

  function automatic logic [VA_W-1:0] xw_dir_slot(input logic [VA_W-1:0] base,
                                                  input logic [IDX_W-1:0] didx);
    return base + {{(VA_W-IDX_W-2){1'b0}}, didx, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] xw_tbl_slot(input logic [VPN_W-1:0] frame,
                                                  input logic [IDX_W-1:0] tidx);
    return {frame, tidx, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] xw_phys(input logic [VPN_W-1:0] frame,
                                              input logic [PG_SH-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic xw_tbl_wb(input logic acc, input logic dirty, input logic wr);
    return !acc || (wr && !dirty);
  endfunction

  function automatic xw_ent_t xw_merge(input logic [VPN_W-1:0] frame,
                                       input logic t_wr, input logic t_usr,
                                       input logic t_dirty, input logic d_wr,
                                       input logic d_usr, input logic wr);
    xw_ent_t e;
    e.frame   = frame;
    e.wr_ok   = t_wr & d_wr;
    e.usr_ok  = t_usr & d_usr;
    e.dirty   = t_dirty | wr;
    e.present = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/xw_tcache.sv
module xw_tcache
  import xw_pkg::*;
#(
  parameter  int SETS = 16,
  localparam int IW   = $clog2(SETS),
  localparam int TW   = VPN_W - IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_hit,
  output xw_ent_t          look_ent,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  xw_ent_t          fill_ent,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_idx,
  output logic             any_valid
);
  logic [SETS-1:0] vld;
  logic [TW-1:0]   tag_a [SETS];
  xw_ent_t         ent_a [SETS];
  logic [IW-1:0]   look_idx;
  logic [IW-1:0]   fill_idx;

  assign look_idx = look_vpn[IW-1:0];
  assign fill_idx = fill_vpn[IW-1:0];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic          v_q;
    logic [TW-1:0] t_q;
    xw_ent_t       e_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        e_q <= '0;
      end else if (clr_en && clr_idx == IW'(s)) begin
        v_q <= 1'b0;
      end else if (fill_en && fill_idx == IW'(s)) begin
        v_q <= 1'b1;
        t_q <= fill_vpn[VPN_W-1:IW];
        e_q <= fill_ent;
      end
    end
    assign vld[s]   = v_q;
    assign tag_a[s] = t_q;
    assign ent_a[s] = e_q;
  end

  assign look_hit  = vld[look_idx] && (tag_a[look_idx] == look_vpn[VPN_W-1:IW]);
  assign look_ent  = ent_a[look_idx];
  assign any_valid = |vld;

  assert_clr_fill_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> !fill_en);
  assert_fill_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> any_valid);
endmodule

// File: rtl/xw_perm.sv
module xw_perm (
  input  logic       present,
  input  logic       wr_ok,
  input  logic       usr_ok,
  input  logic       wr,
  input  logic       cpl_nz,
  input  logic       wp_en,
  output logic       fault,
  output logic [2:0] ecode
);
  logic priv_viol;
  logic ro_viol;

  assign priv_viol = !usr_ok && cpl_nz;
  assign ro_viol   = wr && wp_en && !wr_ok;
  assign fault     = !present || priv_viol || ro_viol;
  assign ecode     = {cpl_nz, wr, present};
endmodule

// File: rtl/xw_seq.sv
module xw_seq
  import xw_pkg::*;
#(
  parameter  int SETS = 16,
  localparam int IW   = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_lin,
  input  logic             req_wr,
  input  logic             req_cpl_nz,
  input  logic             req_wp,
  input  logic [VA_W-1:0]  dir_base,
  output logic [VA_W-1:0]  act_lin,
  output logic             act_wr,
  output logic             act_cpl_nz,
  output logic             act_wp,
  output logic             done,
  output xw_res_t          done_res,
  output logic [VPN_W-1:0] look_vpn,
  input  logic             look_hit,
  input  xw_ent_t          look_ent,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_vpn,
  output xw_ent_t          fill_ent,
  output logic             clr_en,
  output logic [IW-1:0]    clr_idx,
  input  logic             any_valid,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [VA_W-1:0]  mem_wdata,
  input  logic             mem_rvalid,
  input  logic [VA_W-1:0]  mem_rdata
);
  typedef enum logic [3:0] {
    S_IDLE, S_FLUSH, S_LOOK, S_DIR_RQ, S_DIR_WT, S_DIR_WB,
    S_TBL_RQ, S_TBL_WT, S_TBL_WB, S_RESP
  } st_t;

  st_t             st;
  logic            flush_pend;
  logic [IW-1:0]   clr_cnt;
  logic [VA_W-1:0] lin_q, base_q, pde_q, pte_q;
  logic            wr_q, cpl_q, wp_q;
  xw_res_t         res_q;

  // named internal events
  logic            hit_ok;
  logic            clr_last;
  logic [VA_W-1:0] pte_cur;
  logic            tbl_wb_need;
  xw_ent_t         merged;
  logic            dir_phase;

  assign hit_ok      = look_hit && (!wr_q || look_ent.dirty);
  assign clr_last    = (clr_cnt == IW'(SETS - 1));
  assign pte_cur     = (st == S_TBL_WT) ? mem_rdata : pte_q;
  assign tbl_wb_need = xw_tbl_wb(pte_cur[B_ACC], pte_cur[B_DIRTY], wr_q);
  assign merged      = xw_merge(pte_cur[VA_W-1:PG_SH], pte_cur[B_WR], pte_cur[B_USR],
                                pte_cur[B_DIRTY], pde_q[B_WR], pde_q[B_USR], wr_q);
  assign dir_phase   = (st == S_DIR_RQ) || (st == S_DIR_WB);

  assign req_ready = (st == S_IDLE) && !flush_pend;
  assign done      = (st == S_RESP);
  assign done_res  = res_q;
  assign act_lin    = lin_q;
  assign act_wr     = wr_q;
  assign act_cpl_nz = cpl_q;
  assign act_wp     = wp_q;

  assign look_vpn = lin_q[VA_W-1:PG_SH];
  assign fill_vpn = lin_q[VA_W-1:PG_SH];
  assign fill_ent = merged;
  assign fill_en  = (st == S_TBL_WT && mem_rvalid && mem_rdata[B_PRES] && !tbl_wb_need) ||
                    (st == S_TBL_WB && mem_ready);
  assign clr_en   = (st == S_FLUSH);
  assign clr_idx  = clr_cnt;

  assign mem_valid = (st == S_DIR_RQ) || (st == S_DIR_WB) ||
                     (st == S_TBL_RQ) || (st == S_TBL_WB);
  assign mem_we    = (st == S_DIR_WB) || (st == S_TBL_WB);
  assign mem_addr  = dir_phase ? xw_dir_slot(base_q, lin_q[VA_W-1:VA_W-IDX_W])
                               : xw_tbl_slot(pde_q[VA_W-1:PG_SH], lin_q[PG_SH+IDX_W-1:PG_SH]);
  assign mem_wdata = (st == S_DIR_WB) ? (pde_q | (32'd1 << B_ACC))
                   : (pte_q | (32'd1 << B_ACC) | (wr_q ? (32'd1 << B_DIRTY) : 32'd0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      flush_pend <= 1'b0;
      clr_cnt    <= '0;
      lin_q      <= '0;
      base_q     <= '0;
      pde_q      <= '0;
      pte_q      <= '0;
      wr_q       <= 1'b0;
      cpl_q      <= 1'b0;
      wp_q       <= 1'b0;
      res_q      <= '0;
    end else begin
      if (flush) flush_pend <= 1'b1;
      else if (st == S_IDLE && flush_pend) flush_pend <= 1'b0;
      case (st)
        S_IDLE: begin
          if (flush_pend) begin
            if (any_valid) begin
              st      <= S_FLUSH;
              clr_cnt <= '0;
            end
          end else if (req_valid) begin
            lin_q  <= req_lin;
            base_q <= dir_base;
            wr_q   <= req_wr;
            cpl_q  <= req_cpl_nz;
            wp_q   <= req_wp;
            st     <= S_LOOK;
          end
        end
        S_FLUSH: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_last) st <= S_IDLE;
        end
        S_LOOK: begin
          if (hit_ok) begin
            res_q <= '{frame: look_ent.frame, wr_ok: look_ent.wr_ok,
                       usr_ok: look_ent.usr_ok, present: 1'b1};
            st    <= S_RESP;
          end else begin
            st <= S_DIR_RQ;
          end
        end
        S_DIR_RQ: if (mem_ready) st <= S_DIR_WT;
        S_DIR_WT: begin
          if (mem_rvalid) begin
            pde_q <= mem_rdata;
            if (!mem_rdata[B_PRES]) begin
              res_q <= '0;
              st    <= S_RESP;
            end else if (!mem_rdata[B_ACC]) begin
              st <= S_DIR_WB;
            end else begin
              st <= S_TBL_RQ;
            end
          end
        end
        S_DIR_WB: if (mem_ready) st <= S_TBL_RQ;
        S_TBL_RQ: if (mem_ready) st <= S_TBL_WT;
        S_TBL_WT: begin
          if (mem_rvalid) begin
            pte_q <= mem_rdata;
            if (!mem_rdata[B_PRES]) begin
              res_q <= '0;
              st    <= S_RESP;
            end else if (tbl_wb_need) begin
              st <= S_TBL_WB;
            end else begin
              res_q <= '{frame: merged.frame, wr_ok: merged.wr_ok,
                         usr_ok: merged.usr_ok, present: 1'b1};
              st    <= S_RESP;
            end
          end
        end
        S_TBL_WB: begin
          if (mem_ready) begin
            res_q <= '{frame: merged.frame, wr_ok: merged.wr_ok,
                       usr_ok: merged.usr_ok, present: 1'b1};
            st    <= S_RESP;
          end
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_wb_accessed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_wdata[B_ACC]);
  assert_wb_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && !dir_phase && wr_q |-> mem_wdata[B_DIRTY]);
  assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_no_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter  int SETS = 16,
  localparam int IW   = $clog2(SETS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] dir_base,
  input  logic        wp_en,
  input  logic        flush,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_wr,
  input  logic        req_cpl_nz,
  output logic        resp_valid,
  output logic [31:0] resp_phys,
  output logic        resp_fault,
  output logic [2:0]  resp_ecode,
  output logic [31:0] fault_addr,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [VA_W-1:0]  act_lin;
  logic             act_wr, act_cpl_nz, act_wp;
  logic             done;
  xw_res_t          done_res;
  logic [VPN_W-1:0] look_vpn, fill_vpn;
  logic             look_hit, fill_en, clr_en, any_valid;
  xw_ent_t          look_ent, fill_ent;
  logic [IW-1:0]    clr_idx;
  logic             fault_w;
  logic [2:0]       ecode_w;

  xw_seq #(.SETS(SETS)) u_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_wr(req_wr), .req_cpl_nz(req_cpl_nz), .req_wp(wp_en), .dir_base(dir_base),
    .act_lin(act_lin), .act_wr(act_wr), .act_cpl_nz(act_cpl_nz), .act_wp(act_wp),
    .done(done), .done_res(done_res),
    .look_vpn(look_vpn), .look_hit(look_hit), .look_ent(look_ent),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ent(fill_ent),
    .clr_en(clr_en), .clr_idx(clr_idx), .any_valid(any_valid),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  xw_tcache #(.SETS(SETS)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .look_vpn(look_vpn), .look_hit(look_hit), .look_ent(look_ent),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ent(fill_ent),
    .clr_en(clr_en), .clr_idx(clr_idx), .any_valid(any_valid)
  );

  xw_perm u_perm (
    .present(done_res.present), .wr_ok(done_res.wr_ok), .usr_ok(done_res.usr_ok),
    .wr(act_wr), .cpl_nz(act_cpl_nz), .wp_en(act_wp),
    .fault(fault_w), .ecode(ecode_w)
  );

  assign resp_valid = done;
  assign resp_phys  = xw_phys(done_res.frame, act_lin[PG_SH-1:0]);
  assign resp_fault = fault_w;
  assign resp_ecode = ecode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_addr <= '0;
    else if (done && fault_w) fault_addr <= act_lin;
  end

  assert_fault_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |=> fault_addr == $past(act_lin));
  assert_absent_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ecode[0] |-> resp_fault && resp_phys[31:12] == '0);
endmodule

// File: tb/xlat_walker_tb_top.sv
`timescale 1ns/1ps
module xlat_walker_tb_top;
  localparam int SETS = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] dir_base = BASE;
  logic        wp_en = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_wr = 1'b0;
  logic        req_cpl_nz = 1'b0;
  logic        resp_valid;
  logic [31:0] resp_phys;
  logic        resp_fault;
  logic [2:0]  resp_ecode;
  logic [31:0] fault_addr;
  logic        mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  xlat_walker #(.SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .wp_en(wp_en), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin), .req_wr(req_wr),
    .req_cpl_nz(req_cpl_nz), .resp_valid(resp_valid), .resp_phys(resp_phys),
    .resp_fault(resp_fault), .resp_ecode(resp_ecode), .fault_addr(fault_addr),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: 16 KB, ready withheld every third cycle, read data one cycle after acceptance
  logic [31:0] mem [4096];
  int stall_ctr = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  assign mem_ready = (stall_ctr % 3) != 2;

  function automatic logic [31:0] init_word(input int i);
    case (i * 4)
      32'h1000: return 32'h0000_2007;
      32'h1004: return 32'h0000_3025;
      32'h2000: return 32'h1234_5007;
      32'h2004: return 32'h0ABC_D025;
      32'h2008: return 32'h0077_7063;
      32'h3000: return 32'h5555_5067;
      default:  return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    stall_ctr  <= stall_ctr + 1;
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= init_word(i);
      rd_cnt    <= 0;
      wr_cnt    <= 0;
      mem_rdata <= '0;
    end else if (mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata  <= mem[mem_addr[13:2]];
        mem_rvalid <= 1'b1;
        rd_cnt     <= rd_cnt + 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // bench-side cache model
  logic        mv [SETS];
  logic [19:0] mtag [SETS];
  logic [19:0] mframe [SETS];
  logic        mw [SETS], mu [SETS], md [SETS];
  initial for (int i = 0; i < SETS; i++) mv[i] = 1'b0;

  typedef struct packed {
    logic [31:0] phys;
    logic        fault;
    logic [2:0]  ec;
    logic [1:0]  nr;
    logic [1:0]  nw;
  } exp_t;
  exp_t  sb [$];
  string tg [$];

  // scoreboard monitor
  int   last_rd = 0;
  int   last_wr = 0;
  exp_t e;
  string t;
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12 response without request", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        t = tg.pop_front();
        chk(resp_phys == e.phys, {t, " R8 phys"}, resp_phys, e.phys);
        chk(resp_fault == e.fault, {t, " R6 fault"}, 32'(resp_fault), 32'(e.fault));
        chk(resp_ecode == e.ec, {t, " R7 ecode"}, 32'(resp_ecode), 32'(e.ec));
        chk(rd_cnt - last_rd == int'(e.nr), {t, " R1 reads"}, 32'(rd_cnt - last_rd), 32'(e.nr));
        chk(wr_cnt - last_wr == int'(e.nw), {t, " R4 writes"}, 32'(wr_cnt - last_wr), 32'(e.nw));
      end
      last_rd = rd_cnt;
      last_wr = wr_cnt;
    end
  end

  task automatic do_req(input logic [31:0] lin, input bit wr, input bit cpl, input bit wp, input string tag);
    logic [19:0] vpn;
    logic [3:0]  idx;
    logic [31:0] pde, pte;
    bit          p, w, u, hit;
    logic [19:0] fr;
    int          nr, nw;
    exp_t        x;
    vpn = lin[31:12];
    idx = vpn[3:0];
    hit = mv[idx] && mtag[idx] == vpn && (!wr || md[idx]);
    p = 0; w = 0; u = 0; fr = '0; nr = 0; nw = 0;
    if (hit) begin
      p = 1; w = mw[idx]; u = mu[idx]; fr = mframe[idx];
    end else begin
      pde = mem[(BASE + {20'd0, lin[31:22], 2'b00}) >> 2];
      nr = 1;
      if (pde[0]) begin
        if (!pde[5]) nw++;
        pte = mem[{pde[13:12], lin[21:12]}];
        nr = 2;
        if (pte[0]) begin
          if (!pte[5] || (wr && !pte[6])) nw++;
          p = 1; fr = pte[31:12]; w = pde[1] & pte[1]; u = pde[2] & pte[2];
          mv[idx] = 1'b1; mtag[idx] = vpn; mframe[idx] = fr;
          mw[idx] = w; mu[idx] = u; md[idx] = pte[6] | wr;
        end
      end
    end
    x.phys  = {fr, lin[11:0]};
    x.fault = !p || (!u && cpl) || (wr && wp && !w);
    x.ec    = {cpl, wr, p};
    x.nr    = 2'(nr);
    x.nw    = 2'(nw);
    sb.push_back(x);
    tg.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_lin = lin; req_wr = wr; req_cpl_nz = cpl; wp_en = wp;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    if (x.fault) chk(fault_addr == lin, {tag, " R7 fault_addr"}, fault_addr, lin);
  endtask

  task automatic do_flush(input int exp_low, input string tag);
    int n;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    n = 0;
    while (!req_ready) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_low, {tag, " R10 ready low cycles"}, 32'(n), 32'(exp_low));
    for (int i = 0; i < SETS; i++) mv[i] = 1'b0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12 reset ready", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R12 reset resp_valid", 32'(resp_valid), 32'd0);
    chk(mem_valid == 1'b0, "R12 reset mem_valid", 32'(mem_valid), 32'd0);
    chk(fault_addr == 32'd0, "R12 reset fault_addr", fault_addr, 32'd0);

    do_req(32'h0000_0123, 0, 0, 0, "R1 R3 first walk");
    chk(mem[32'h1000 >> 2] == 32'h0000_2027, "R3 directory accessed", mem[32'h1000 >> 2], 32'h0000_2027);
    chk(mem[32'h2000 >> 2] == 32'h1234_5027, "R4 table accessed", mem[32'h2000 >> 2], 32'h1234_5027);
    do_req(32'h0000_0123, 0, 0, 0, "R9 read hit");
    do_req(32'h0000_0123, 1, 0, 0, "R9 R4 write to clean entry");
    chk(mem[32'h2000 >> 2] == 32'h1234_5067, "R4 dirty set", mem[32'h2000 >> 2], 32'h1234_5067);
    do_req(32'h0000_0456, 1, 0, 0, "R9 write hit dirty");
    do_req(32'h0000_1ABC, 0, 1, 0, "R5 user read");
    do_req(32'h0000_1ABC, 1, 0, 1, "R6 write protect fault");
    chk(mem[32'h2004 >> 2] == 32'h0ABC_D065, "R4 dirty set on fault", mem[32'h2004 >> 2], 32'h0ABC_D065);
    do_req(32'h0000_1ABC, 1, 0, 0, "R6 write protect off");
    do_req(32'h0000_2004, 0, 1, 0, "R6 supervisor fault");
    do_req(32'h0000_2004, 0, 0, 0, "R6 supervisor ok");
    do_req(32'h0000_3000, 0, 0, 0, "R2 table absent");
    do_req(32'h0080_0010, 1, 1, 0, "R2 directory absent");
    do_req(32'h0040_0FFF, 0, 0, 0, "R5 merged read");
    do_req(32'h0040_0FFF, 1, 0, 1, "R5 merged read-only");
    do_req(32'h0000_0123, 0, 0, 0, "R9 evicted");
    do_flush(SETS + 1, "R10 full");
    do_req(32'h0000_0123, 0, 0, 0, "R10 miss after flush");
    do_flush(SETS + 1, "R10 refilled");
    do_flush(1, "R10 empty skip");
    do_req(32'h0000_2004, 0, 1, 0, "R10 R6 after empty flush");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R12 run did not complete");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule